// File: doc/BRIEF.md
# Serial Bus Controller Interrupt Status Unit

This unit gathers the event and level conditions of a serial bus controller into one 12-bit raw status vector. A programmable enable mask is applied to that vector to form a masked status and a single interrupt line. Event conditions such as overflow, underflow, abort and bus start/stop are captured by sticky latches. Two level conditions are recomputed every cycle from the FIFO fill levels and their programmed thresholds: the transmit-low flag and the receive-high flag. The activity flag follows the bus-busy input.

Software reaches the unit through a simple register port. Reads return data one cycle later. Some addresses hold the mask, the two thresholds, the raw and masked status and the accumulated abort cause. A further set of addresses clears a status bit when read. There is one such address per clearable event and one that clears every software-clearable bit at once. Each clear read reports whether the bit it targets was set before the clear. The bus engine supplies single-cycle event pulses, a bus-busy level, an abort-cause vector that comes with each abort pulse, and the two FIFO levels.

Top module: `sbc_irq_stat`

## Requirements
- R1: Raw status bit positions are: rx underflow 0, rx overflow 1, rx above threshold 2, tx overflow 3, tx below threshold 4, abort 6, activity 8, stop seen 9, start seen 10, general call 11. Bits 5, 7 and 12 and above read 0. Register addresses: mask 0x00, masked status 0x04, raw status 0x08, rx threshold 0x0C, tx threshold 0x10, abort cause 0x14.
- R2: The mask resets to 0x8FF. Masked status equals raw status AND mask. `irq` is high exactly when any masked status bit is 1.
- R3: The tx-below-threshold bit is 1 while the tx level is less than or equal to the effective tx threshold, and 0 once the level is above it. The bit lags the level by one cycle.
- R4: The rx-above-threshold bit is 1 while the rx level is greater than or equal to the effective rx threshold, and 0 once the level is below it. The bit lags the level by one cycle.
- R5: A threshold register holds 8 bits. Any programmed value of DEPTH (16) or more acts as DEPTH.
- R6: The rx underflow, rx overflow, tx overflow, abort, stop, start and general-call bits stay set until their own clear address is read. The clear addresses are 0x24, 0x28, 0x2C, 0x30, 0x38, 0x3C and 0x40 respectively. Every clear read returns, in bit 0 of the read data, the targeted bit as it was before the clear; all other bits read 0.
- R7: Reading the global clear address 0x20 clears all sticky bits and the abort cause. It returns 1 in bit 0 if any software-clearable bit was set. The two level bits are not affected.
- R8: The activity bit is 1 in the cycle after `bus_busy` is high and 0 in the cycle after it is low. Reading its clear address 0x34 while the bus is busy leaves it set.
- R9: An event pulse in the same cycle as a clear read of its bit (dedicated or global) leaves the bit set.
- R10: On each abort pulse, `abrt_src` is ORed into the abort-cause register. The register is cleared by the abort clear read or the global clear read, but an abort pulse in the same cycle still loads its cause.
- R11: After reset all sticky bits, the activity bit, the abort cause and both thresholds are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_rx_under | input | 1 | Pulse: read from empty rx FIFO |
| evt_rx_over | input | 1 | Pulse: rx data lost |
| evt_tx_over | input | 1 | Pulse: write to full tx FIFO |
| evt_tx_abort | input | 1 | Pulse: transfer aborted |
| abrt_src | input | CAUSE_W | Abort cause bits, valid with `evt_tx_abort` |
| evt_stop_det | input | 1 | Pulse: stop condition seen |
| evt_start_det | input | 1 | Pulse: start or repeated start seen |
| evt_gen_call | input | 1 | Pulse: general call received |
| bus_busy | input | 1 | Bus activity level |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Combined interrupt |

## Verification
The threshold comparison is driven from a table of level and threshold pairs. The table places levels exactly at, one below and one above each threshold, which separates the inclusive comparisons from strict ones. It also includes thresholds of 15, 16 and 200, which show whether values at or beyond the FIFO depth are limited to the depth. Each sticky event is raised by itself and then cleared through its own address, so a swapped bit position or a wrong clear decode shows up as a mismatch. Clear reads that coincide with a new event, and clears of activity while the bus is busy, separate the correct priority from a design where the clear wins.

// File: rtl/sbc_irq_pkg.sv
package sbc_irq_pkg;

    localparam int STAT_W = 12;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int N_STICKY = 7;
    localparam logic [STAT_W-1:0] MASK_RST = 12'h8FF;

    // Raw status layout; bit positions are decoded by software.
    typedef struct packed {
        logic gen_call;   // 11
        logic start_det;  // 10
        logic stop_det;   // 9
        logic activity;   // 8
        logic rsv7;       // 7
        logic tx_abrt;    // 6
        logic rsv5;       // 5
        logic tx_low;     // 4
        logic tx_over;    // 3
        logic rx_high;    // 2
        logic rx_over;    // 1
        logic rx_under;   // 0
    } stat_t;

    typedef enum logic [ADDR_W-1:0] {
        A_MASK      = 8'h00,
        A_MSTAT     = 8'h04,
        A_RAW       = 8'h08,
        A_RX_THR    = 8'h0C,
        A_TX_THR    = 8'h10,
        A_CAUSE     = 8'h14,
        A_CLR_ALL   = 8'h20,
        A_CLR_RXU   = 8'h24,
        A_CLR_RXO   = 8'h28,
        A_CLR_TXO   = 8'h2C,
        A_CLR_ABRT  = 8'h30,
        A_CLR_ACT   = 8'h34,
        A_CLR_STOP  = 8'h38,
        A_CLR_START = 8'h3C,
        A_CLR_GC    = 8'h40
    } reg_addr_e;

    typedef struct packed {
        logic all;
        logic gen_call;
        logic start_det;
        logic stop_det;
        logic activity;
        logic tx_abrt;
        logic tx_over;
        logic rx_over;
        logic rx_under;
    } clr_t;

    // Thresholds at or beyond the FIFO depth act as the depth.
    function automatic int unsigned eff_thr(int unsigned thr, int unsigned depth);
        return (thr >= depth) ? depth : thr;
    endfunction

endpackage

// File: rtl/sbc_irq_sticky.sv
module sbc_irq_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Set has priority over clear.
    always_ff @(posedge clk) begin
        if (rst)
            q_o <= 1'b0;
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end
endmodule

// File: rtl/sbc_irq_level.sv
module sbc_irq_level #(
    parameter int DEPTH = 16,
    parameter int THR_W = 8,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [THR_W-1:0] tx_thr,
    input  logic [THR_W-1:0] rx_thr,
    output logic             tx_low_q,
    output logic             rx_high_q
);
    import sbc_irq_pkg::*;

    logic tx_low_d, rx_high_d;

    always_comb begin
        tx_low_d  = int'(tx_level) <= eff_thr(int'(tx_thr), DEPTH);
        rx_high_d = int'(rx_level) >= eff_thr(int'(rx_thr), DEPTH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_low_q  <= 1'b0;
            rx_high_q <= 1'b0;
        end else begin
            tx_low_q  <= tx_low_d;
            rx_high_q <= rx_high_d;
        end
    end
endmodule

// File: rtl/sbc_irq_regs.sv
module sbc_irq_regs #(
    parameter int THR_W = 8
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  reg_wr,
    input  logic                                  reg_rd,
    input  logic [sbc_irq_pkg::ADDR_W-1:0]        reg_addr,
    input  logic [sbc_irq_pkg::DATA_W-1:0]        reg_wdata,
    output logic [sbc_irq_pkg::STAT_W-1:0]        mask_q,
    output logic [THR_W-1:0]                      rx_thr_q,
    output logic [THR_W-1:0]                      tx_thr_q,
    output sbc_irq_pkg::clr_t                     clr
);
    import sbc_irq_pkg::*;

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= MASK_RST;
            rx_thr_q <= '0;
            tx_thr_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_MASK)   mask_q   <= reg_wdata[STAT_W-1:0];
            if (reg_addr == A_RX_THR) rx_thr_q <= reg_wdata[THR_W-1:0];
            if (reg_addr == A_TX_THR) tx_thr_q <= reg_wdata[THR_W-1:0];
        end
    end

    always_comb begin
        clr           = '0;
        clr.all       = reg_rd && (reg_addr == A_CLR_ALL);
        clr.rx_under  = reg_rd && (reg_addr == A_CLR_RXU);
        clr.rx_over   = reg_rd && (reg_addr == A_CLR_RXO);
        clr.tx_over   = reg_rd && (reg_addr == A_CLR_TXO);
        clr.tx_abrt   = reg_rd && (reg_addr == A_CLR_ABRT);
        clr.activity  = reg_rd && (reg_addr == A_CLR_ACT);
        clr.stop_det  = reg_rd && (reg_addr == A_CLR_STOP);
        clr.start_det = reg_rd && (reg_addr == A_CLR_START);
        clr.gen_call  = reg_rd && (reg_addr == A_CLR_GC);
    end
endmodule

// File: rtl/sbc_irq_stat.sv
module sbc_irq_stat #(
    parameter int DEPTH   = 16,
    parameter int THR_W   = 8,
    parameter int CAUSE_W = 17,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               evt_rx_under,
    input  logic               evt_rx_over,
    input  logic               evt_tx_over,
    input  logic               evt_tx_abort,
    input  logic [CAUSE_W-1:0] abrt_src,
    input  logic               evt_stop_det,
    input  logic               evt_start_det,
    input  logic               evt_gen_call,
    input  logic               bus_busy,
    input  logic [LVL_W-1:0]   tx_level,
    input  logic [LVL_W-1:0]   rx_level,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [7:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq
);
    import sbc_irq_pkg::*;

    logic [STAT_W-1:0]   mask_q;
    logic [THR_W-1:0]    rx_thr_q, tx_thr_q;
    clr_t                clr;
    logic                tx_low_q, rx_high_q;
    logic                act_q;
    logic [N_STICKY-1:0] evt_vec, clr_vec, sticky_q;
    logic [CAUSE_W-1:0]  cause_q;
    stat_t               raw;
    logic [STAT_W-1:0]   masked;
    logic [DATA_W-1:0]   rd_mux;
    logic                cause_clr;

    sbc_irq_regs #(.THR_W(THR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .mask_q    (mask_q),
        .rx_thr_q  (rx_thr_q),
        .tx_thr_q  (tx_thr_q),
        .clr       (clr)
    );

    sbc_irq_level #(.DEPTH(DEPTH), .THR_W(THR_W), .LVL_W(LVL_W)) u_level (
        .clk       (clk),
        .rst       (rst),
        .tx_level  (tx_level),
        .rx_level  (rx_level),
        .tx_thr    (tx_thr_q),
        .rx_thr    (rx_thr_q),
        .tx_low_q  (tx_low_q),
        .rx_high_q (rx_high_q)
    );

    assign evt_vec = {evt_gen_call, evt_start_det, evt_stop_det, evt_tx_abort,
                      evt_tx_over, evt_rx_over, evt_rx_under};
    assign clr_vec = {clr.gen_call, clr.start_det, clr.stop_det, clr.tx_abrt,
                      clr.tx_over, clr.rx_over, clr.rx_under} | {N_STICKY{clr.all}};

    for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
        sbc_irq_sticky u_bit (
            .clk   (clk),
            .rst   (rst),
            .set_i (evt_vec[g]),
            .clr_i (clr_vec[g]),
            .q_o   (sticky_q[g])
        );
    end

    // Activity follows the bus; a clear read cannot drop it while busy,
    // and it falls on its own once the bus is idle.
    always_ff @(posedge clk) begin
        if (rst) act_q <= 1'b0;
        else     act_q <= bus_busy;
    end

    assign cause_clr = clr.tx_abrt | clr.all;

    always_ff @(posedge clk) begin
        if (rst)
            cause_q <= '0;
        else if (evt_tx_abort)
            cause_q <= (cause_clr ? '0 : cause_q) | abrt_src;
        else if (cause_clr)
            cause_q <= '0;
    end

    always_comb begin
        raw           = '0;
        raw.rx_under  = sticky_q[0];
        raw.rx_over   = sticky_q[1];
        raw.tx_over   = sticky_q[2];
        raw.tx_abrt   = sticky_q[3];
        raw.stop_det  = sticky_q[4];
        raw.start_det = sticky_q[5];
        raw.gen_call  = sticky_q[6];
        raw.activity  = act_q;
        raw.tx_low    = tx_low_q;
        raw.rx_high   = rx_high_q;
    end

    assign masked = raw & mask_q;
    assign irq    = |masked;

    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            A_MASK:      rd_mux[STAT_W-1:0]  = mask_q;
            A_MSTAT:     rd_mux[STAT_W-1:0]  = masked;
            A_RAW:       rd_mux[STAT_W-1:0]  = raw;
            A_RX_THR:    rd_mux[THR_W-1:0]   = rx_thr_q;
            A_TX_THR:    rd_mux[THR_W-1:0]   = tx_thr_q;
            A_CAUSE:     rd_mux[CAUSE_W-1:0] = cause_q;
            A_CLR_ALL:   rd_mux[0] = (|sticky_q) | act_q;
            A_CLR_RXU:   rd_mux[0] = raw.rx_under;
            A_CLR_RXO:   rd_mux[0] = raw.rx_over;
            A_CLR_TXO:   rd_mux[0] = raw.tx_over;
            A_CLR_ABRT:  rd_mux[0] = raw.tx_abrt;
            A_CLR_ACT:   rd_mux[0] = raw.activity;
            A_CLR_STOP:  rd_mux[0] = raw.stop_det;
            A_CLR_START: rd_mux[0] = raw.start_det;
            A_CLR_GC:    rd_mux[0] = raw.gen_call;
            default:     rd_mux = '0;
        endcase
    end

    // Registered read returns the pre-clear state.
    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end
endmodule

// File: rtl/sbc_irq_stat_chk.sv
module sbc_irq_stat_chk #(
    parameter int LVL_W   = 5,
    parameter int CAUSE_W = 17
) (
    input logic               clk,
    input logic               rst,
    input logic               irq,
    input logic               bus_busy,
    input logic               evt_rx_over,
    input logic               evt_any,
    input logic               evt_tx_abort,
    input logic [CAUSE_W-1:0] abrt_src,
    input logic [LVL_W-1:0]   tx_level,
    input logic               reg_rd,
    input logic               reg_wr,
    input logic [7:0]         reg_addr,
    input logic [31:0]        reg_wdata,
    input logic [11:0]        raw,
    input logic [CAUSE_W-1:0] cause
);
    import sbc_irq_pkg::*;

    // R2
    mask_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_MASK && reg_wdata[11:0] == 12'h000) |=> !irq);

    // R6
    rxo_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (raw[1] && !(reg_rd && (reg_addr == A_CLR_RXO || reg_addr == A_CLR_ALL))) |=> raw[1]);

    // R9
    rxo_event_wins_chk: assert property (@(posedge clk) disable iff (rst)
        evt_rx_over |=> raw[1]);

    // R8
    busy_activity_chk: assert property (@(posedge clk) disable iff (rst)
        bus_busy |=> raw[8]);

    // R3
    tx_empty_low_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_level == '0) |=> raw[4]);

    // R7
    global_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == A_CLR_ALL && !evt_any && !bus_busy)
        |=> ((raw & 12'hF4B) == 12'h000) && (cause == '0));

    // R10
    cause_accum_chk: assert property (@(posedge clk) disable iff (rst)
        evt_tx_abort |=> ((cause & $past(abrt_src)) == $past(abrt_src)));
endmodule

bind sbc_irq_stat sbc_irq_stat_chk #(.LVL_W(LVL_W), .CAUSE_W(CAUSE_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .irq          (irq),
    .bus_busy     (bus_busy),
    .evt_rx_over  (evt_rx_over),
    .evt_any      (|evt_vec),
    .evt_tx_abort (evt_tx_abort),
    .abrt_src     (abrt_src),
    .tx_level     (tx_level),
    .reg_rd       (reg_rd),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .raw          (raw),
    .cause        (cause_q)
);

// File: tb/test_sbc_irq_stat.sv
module test_sbc_irq_stat;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  ev = '0;
    logic [16:0] abrt_src = '0;
    logic        bus_busy = 1'b0;
    logic [4:0]  tx_level = '0;
    logic [4:0]  rx_level = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sbc_irq_stat i_sbc_irq_stat (
        .clk           (clk),
        .rst           (rst),
        .evt_rx_under  (ev[0]),
        .evt_rx_over   (ev[1]),
        .evt_tx_over   (ev[2]),
        .evt_tx_abort  (ev[3]),
        .abrt_src      (abrt_src),
        .evt_stop_det  (ev[4]),
        .evt_start_det (ev[5]),
        .evt_gen_call  (ev[6]),
        .bus_busy      (bus_busy),
        .tx_level      (tx_level),
        .rx_level      (rx_level),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .irq           (irq)
    );

    typedef struct packed {
        logic [4:0] txl;
        logic [7:0] txt;
        logic       te;
        logic [4:0] rxl;
        logic [7:0] rxt;
        logic       rf;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{5'd0,  8'd0,   1'b1, 5'd0,  8'd0,   1'b1},
        '{5'd1,  8'd0,   1'b0, 5'd3,  8'd4,   1'b0},
        '{5'd4,  8'd4,   1'b1, 5'd4,  8'd4,   1'b1},
        '{5'd5,  8'd4,   1'b0, 5'd5,  8'd4,   1'b1},
        '{5'd16, 8'd15,  1'b0, 5'd15, 8'd16,  1'b0},
        '{5'd16, 8'd200, 1'b1, 5'd16, 8'd200, 1'b1},
        '{5'd15, 8'd255, 1'b1, 5'd15, 8'd255, 1'b0},
        '{5'd16, 8'd16,  1'b1, 5'd16, 8'd15,  1'b1}
    };

    function automatic int bitpos(int i);
        case (i)
            0: return 0;  1: return 1;  2: return 3;  3: return 6;
            4: return 9;  5: return 10; default: return 11;
        endcase
    endfunction

    function automatic logic [7:0] clraddr(int i);
        case (i)
            0: return 8'h24; 1: return 8'h28; 2: return 8'h2C; 3: return 8'h30;
            4: return 8'h38; 5: return 8'h3C; default: return 8'h40;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        reg_rd   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [6:0] m);
        ev = m;
        @(posedge clk);
        @(negedge clk);
        ev = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();

        // R11 / R2: reset state
        rd(8'h00, d); check("R2 mask reset", d, 32'h8FF);
        rd(8'h08, d); check("R11 raw after reset", d, 32'h014);
        rd(8'h14, d); check("R11 cause after reset", d, 32'h0);
        rd(8'h0C, d); check("R11 rx threshold reset", d, 32'h0);
        check("R2 irq from level bits", {31'b0, irq}, 32'h1);

        // R3 R4 R5: threshold table
        for (int i = 0; i < 8; i++) begin
            wr(8'h10, {24'b0, VECS[i].txt});
            wr(8'h0C, {24'b0, VECS[i].rxt});
            tx_level = VECS[i].txl;
            rx_level = VECS[i].rxl;
            step();
            rd(8'h08, d);
            check("R3 R4 R5 level flags", d,
                  {27'b0, VECS[i].te, 1'b0, VECS[i].rf, 2'b0});
        end

        // Quiet base: both level bits low
        wr(8'h10, 32'd0);
        wr(8'h0C, 32'd3);
        tx_level = 5'd5;
        rx_level = 5'd0;
        step();
        rd(8'h08, d); check("R3 R4 quiet base", d, 32'h0);

        // R1 R6: each sticky event and its own clear
        for (int i = 0; i < 7; i++) begin
            pulse(7'(1 << i));
            rd(8'h08, d);       check("R1 bit position", d, 32'(1 << bitpos(i)));
            rd(clraddr(i), d);  check("R6 clear returns set", d, 32'h1);
            rd(8'h08, d);       check("R6 cleared", d, 32'h0);
            rd(clraddr(i), d);  check("R6 clear returns clear", d, 32'h0);
        end

        // R6: a foreign clear leaves the bit
        pulse(7'b0000010);
        rd(8'h24, d); check("R6 other clear returns 0", d, 32'h0);
        rd(8'h08, d); check("R6 stays latched", d, 32'h002);

        // R2: masking
        pulse(7'b0010000);
        rd(8'h04, d); check("R2 masked default", d, 32'h002);
        check("R2 irq on", {31'b0, irq}, 32'h1);
        wr(8'h00, 32'h200);
        rd(8'h04, d); check("R2 masked stop only", d, 32'h200);
        wr(8'h00, 32'h004);
        check("R2 irq off when masked", {31'b0, irq}, 32'h0);
        wr(8'h00, 32'h8FF);

        // R7: global clear
        abrt_src = 17'h01001;
        tx_level = 5'd0;
        pulse(7'b0011110);
        abrt_src = '0;
        rd(8'h14, d); check("R10 cause loaded", d, 32'h01001);
        rd(8'h20, d); check("R7 global returns set", d, 32'h1);
        rd(8'h08, d); check("R7 only level bit left", d, 32'h010);
        rd(8'h14, d); check("R7 cause cleared", d, 32'h0);
        rd(8'h20, d); check("R7 global returns clear", d, 32'h0);
        tx_level = 5'd5;
        step();

        // R10: cause accumulation and abort clear
        abrt_src = 17'h00001; pulse(7'b0001000);
        abrt_src = 17'h10000; pulse(7'b0001000);
        abrt_src = '0;
        rd(8'h14, d); check("R10 cause ORed", d, 32'h10001);
        rd(8'h30, d); check("R10 abort clear returns set", d, 32'h1);
        rd(8'h14, d); check("R10 cause cleared by abort clear", d, 32'h0);

        // R8: activity
        bus_busy = 1'b1;
        step();
        rd(8'h08, d); check("R8 activity set", d, 32'h100);
        rd(8'h34, d); check("R8 activity clear returns set", d, 32'h1);
        rd(8'h08, d); check("R8 clear ignored while busy", d, 32'h100);
        bus_busy = 1'b0;
        step();
        rd(8'h08, d); check("R8 activity drops when idle", d, 32'h0);

        // R9: event beats simultaneous dedicated clear
        ev = 7'b0000010;
        reg_addr = 8'h28;
        reg_rd = 1'b1;
        step();
        ev = '0;
        reg_rd = 1'b0;
        check("R9 clear returns prior value", reg_rdata, 32'h0);
        rd(8'h08, d); check("R9 event kept over clear", d, 32'h002);
        rd(8'h28, d);

        // R9 R10: event beats simultaneous global clear
        ev = 7'b0011000;
        abrt_src = 17'h00004;
        reg_addr = 8'h20;
        reg_rd = 1'b1;
        step();
        ev = '0;
        abrt_src = '0;
        reg_rd = 1'b0;
        rd(8'h08, d); check("R9 events kept over global clear", d, 32'h240);
        rd(8'h14, d); check("R10 cause kept over global clear", d, 32'h00004);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule